// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a CPU's byte-wide register bus and a bit-level I2C engine. It holds an eighteen-byte window of control and status registers and turns certain register accesses into byte-level bus commands: a start with a 7-bit target address and direction, a byte send, a byte receive and a stop. Each command goes out over a valid/done handshake. The engine answers with an acknowledge flag and, for a receive, a data byte.

Writing the data register sends a byte, and it first opens a write transfer if the bus is idle. A read transfer is opened through the control register. Each later read of the data register pulls one byte. A two-bit pending count inside the control register tells the block to close and reopen the read after each byte until that count reaches zero. While any command is outstanding the CPU access stalls, so the status bits the CPU sees always reflect the command's outcome.

Top module: `i2c_master_regif`

## Requirements
- R1: Offsets 0x01, 0x03 and every offset at or above 0x12 read as 0x00, and writes to them change no register. A read of the data register at offset 0x00 returns 0xFF when the buffer-status flag (status bit5) is clear, and no command is issued.
- R2: After reset every register reads 0x00, except extended status (0x09), which reads 0x8F, and direct control (0x10), which reads 0x0F.
- R3: Writes are stored under these masks: 0x07 with 0xDF, 0x0E with 0x77, 0x10 with 0x07. Offsets 0x02, 0x05, 0x0A, 0x0B, 0x0C, 0x0D and 0x11 store the full byte.
- R4: A write to status (0x08) clears only the bits set in value&0x0A. A write to extended status (0x09) clears only the bits set in value&0x8F.
- R5: A write to 0x0F with bit0 set returns all registers to their reset values and does not store the value. With bit0 clear, the value is stored.
- R6: A data-register write while the bus is idle first issues a write-direction start carrying (low address register 0x04)>>1. An acknowledged start sets status bit0, clears status bit2 and zeroes extended status, then the byte is sent. While the bus is already open, only the send is issued.
- R7: A refused write start or a refused send clears status bit0 and sets status bit2 and extended-status bit0. A refused start sends nothing. A refused send is followed by a stop.
- R8: A control (0x06) write with bit0=1 and bit1=1 first clears status bit0 and issues a stop if the bus is open, then issues a read-direction start. Success sets status bit5, clears bit2 and zeroes extended status. A refusal clears status bit0 and sets status bit2 and extended-status bit0.
- R9: A control write with bit0=1 and bit1=0 clears status bit0 and issues no command. The control byte is always stored as written.
- R10: A data read with status bit5 set issues a receive and returns the received byte, or 0xFF if the engine reports failure. If control bits 5:4 are zero, status bit5 is then cleared.
- R11: If control bits 5:4 are nonzero after a receive, a stop and then a read start to the same address follow, with the status updates of R8. The field is then decremented by one.
- R12: A write to the low address register (0x04) issues a stop when the bus is open, and issues no command when it is idle.
- R13: Command codes on cmd_op are 0 write start, 1 read start, 2 send, 3 receive, 4 stop. cmd_valid, cmd_op and cmd_byte hold until eng_done. cpu_ready is a one-cycle pulse that comes only after every command of the access is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | Byte offset in the window |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete pulse |
| cmd_valid | output | 1 | Command pending to the engine |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Target address or data byte |
| eng_done | input | 1 | Engine finished the command |
| eng_ack | input | 1 | Acknowledge or success of the command |
| eng_rdata | input | 8 | Received byte |

## Verification
The assertions assume that the engine raises eng_done for exactly one cycle, and only while cmd_valid is high. They also assume that the CPU holds cpu_sel and its fields steady until cpu_ready and drops cpu_sel in the following cycle. The bench's engine model answers only a pending command, two cycles after it appears, and clears done at the next falling edge. The CPU tasks raise a request at a falling edge and release it at the first falling edge that shows cpu_ready. The model can be told to refuse a given address, to refuse sends, or to fail a receive, which reaches every error path without breaking these rules.

// File: rtl/i2c_rif_pkg.sv
package i2c_rif_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_START_WR = 3'd0,
    OP_START_RD = 3'd1,
    OP_SEND     = 3'd2,
    OP_RECV     = 3'd3,
    OP_STOP     = 3'd4
  } eng_op_e;

  typedef enum logic [4:0] {
    RID_MDATA, RID_SDATA, RID_LMADR, RID_HMADR, RID_CNTL, RID_MODE,
    RID_STS, RID_EXT, RID_LSADR, RID_HSADR, RID_CLKDIV, RID_IMASK,
    RID_XFR, RID_XCTL, RID_DIRC, RID_INTR, RID_NONE
  } reg_id_e;

  typedef struct packed {
    logic [BYTE_W-1:0] mdata;
    logic [BYTE_W-1:0] sdata;
    logic [BYTE_W-1:0] lmadr;
    logic [BYTE_W-1:0] hmadr;
    logic [BYTE_W-1:0] cntl;
    logic [BYTE_W-1:0] mode;
    logic [BYTE_W-1:0] sts;
    logic [BYTE_W-1:0] ext;
    logic [BYTE_W-1:0] lsadr;
    logic [BYTE_W-1:0] hsadr;
    logic [BYTE_W-1:0] clkdiv;
    logic [BYTE_W-1:0] imask;
    logic [BYTE_W-1:0] xfr;
    logic [BYTE_W-1:0] xctl;
    logic [BYTE_W-1:0] dirc;
    logic [BYTE_W-1:0] intr;
  } regs_t;

  localparam regs_t REGS_RST = '{ext: 8'h8F, dirc: 8'h0F, default: 8'h00};

endpackage

// File: rtl/i2c_rif_decode.sv
module i2c_rif_decode
  import i2c_rif_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BYTES = 18
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           id
);

  always_comb begin
    id = RID_NONE;
    if (int'(addr) < WIN_BYTES) begin
      case (int'(addr))
        0:  id = RID_MDATA;
        2:  id = RID_SDATA;
        4:  id = RID_LMADR;
        5:  id = RID_HMADR;
        6:  id = RID_CNTL;
        7:  id = RID_MODE;
        8:  id = RID_STS;
        9:  id = RID_EXT;
        10: id = RID_LSADR;
        11: id = RID_HSADR;
        12: id = RID_CLKDIV;
        13: id = RID_IMASK;
        14: id = RID_XFR;
        15: id = RID_XCTL;
        16: id = RID_DIRC;
        17: id = RID_INTR;
        default: id = RID_NONE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_rif_cmdport.sv
module i2c_rif_cmdport
  import i2c_rif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  eng_op_e           req_op,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              cmd_valid,
  output eng_op_e           cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [BYTE_W-1:0] eng_rdata,
  output logic              res_valid,
  output logic              res_ack,
  output logic [BYTE_W-1:0] res_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_STOP;
      cmd_byte  <= '0;
      res_valid <= 1'b0;
      res_ack   <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (req && !cmd_valid) begin
        cmd_valid <= 1'b1;
        cmd_op    <= req_op;
        cmd_byte  <= req_byte;
      end else if (cmd_valid && eng_done) begin
        cmd_valid <= 1'b0;
        res_valid <= 1'b1;
        res_ack   <= eng_ack;
        res_data  <= eng_rdata;
      end
    end
  end

  // R13: a pending command is held unchanged until the engine finishes it
  a_r13_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  // R13: the sequencer never requests while a command is outstanding
  a_r13_no_overlap: assert property (@(posedge clk) disable iff (rst)
    req |-> !cmd_valid);

endmodule

// File: rtl/i2c_master_regif.sv
module i2c_master_regif
  import i2c_rif_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BYTES = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rdata
);

  localparam logic [BYTE_W-1:0] STS_W1C = 8'h0A;
  localparam logic [BYTE_W-1:0] EXT_W1C = 8'h8F;
  localparam logic [BYTE_W-1:0] MODE_WM = 8'hDF;
  localparam logic [BYTE_W-1:0] XFR_WM  = 8'h77;
  localparam logic [BYTE_W-1:0] DIRC_WM = 8'h07;
  localparam logic [BYTE_W-1:0] IDLE_RD = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WSEND, S_WSTOP, S_ASTOP, S_RSTOP, S_RSTART,
    S_RECV, S_RRESTOP, S_RRESTART, S_FIN
  } seq_e;

  regs_t             q;
  seq_e              st;
  logic              busy;
  logic              launched;
  logic [BYTE_W-1:0] rdata_q;
  reg_id_e           id;

  logic              cmd_req;
  eng_op_e           req_op;
  logic [BYTE_W-1:0] req_byte;
  eng_op_e           cmd_op_e;
  logic              res_valid;
  logic              res_ack;
  logic [BYTE_W-1:0] res_data;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] start_byte;

  i2c_rif_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr (cpu_addr),
    .id   (id)
  );

  i2c_rif_cmdport u_port (
    .clk       (clk),
    .rst       (rst),
    .req       (cmd_req),
    .req_op    (req_op),
    .req_byte  (req_byte),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op_e),
    .cmd_byte  (cmd_byte),
    .eng_done  (eng_done),
    .eng_ack   (eng_ack),
    .eng_rdata (eng_rdata),
    .res_valid (res_valid),
    .res_ack   (res_ack),
    .res_data  (res_data)
  );

  assign cmd_op     = cmd_op_e;
  assign cpu_ready  = (st == S_FIN);
  assign cpu_rdata  = rdata_q;
  assign start_byte = {1'b0, q.lmadr[BYTE_W-1:1]};

  // command selection per sequencer step
  always_comb begin
    cmd_req  = 1'b0;
    req_op   = OP_STOP;
    req_byte = '0;
    case (st)
      S_WSTART:   begin req_op = OP_START_WR; req_byte = start_byte; end
      S_WSEND:    begin req_op = OP_SEND;     req_byte = q.mdata;    end
      S_RSTART,
      S_RRESTART: begin req_op = OP_START_RD; req_byte = start_byte; end
      S_RECV:     req_op = OP_RECV;
      default:    req_op = OP_STOP;
    endcase
    if (st != S_IDLE && st != S_FIN && !launched) cmd_req = 1'b1;
  end

  // plain register read path
  always_comb begin
    case (id)
      RID_MDATA:  rd_mux = IDLE_RD;
      RID_SDATA:  rd_mux = q.sdata;
      RID_LMADR:  rd_mux = q.lmadr;
      RID_HMADR:  rd_mux = q.hmadr;
      RID_CNTL:   rd_mux = q.cntl;
      RID_MODE:   rd_mux = q.mode;
      RID_STS:    rd_mux = q.sts;
      RID_EXT:    rd_mux = q.ext;
      RID_LSADR:  rd_mux = q.lsadr;
      RID_HSADR:  rd_mux = q.hsadr;
      RID_CLKDIV: rd_mux = q.clkdiv;
      RID_IMASK:  rd_mux = q.imask;
      RID_XFR:    rd_mux = q.xfr;
      RID_XCTL:   rd_mux = q.xctl;
      RID_DIRC:   rd_mux = q.dirc;
      RID_INTR:   rd_mux = q.intr;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= REGS_RST;
      st       <= S_IDLE;
      busy     <= 1'b0;
      launched <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (cmd_req)   launched <= 1'b1;
      if (res_valid) launched <= 1'b0;
      case (st)
        S_IDLE: if (cpu_sel) begin
          st <= S_FIN;
          if (cpu_we) begin
            case (id)
              RID_MDATA: begin
                q.mdata <= cpu_wdata;
                st      <= busy ? S_WSEND : S_WSTART;
              end
              RID_SDATA: q.sdata <= cpu_wdata;
              RID_LMADR: begin
                q.lmadr <= cpu_wdata;
                if (busy) st <= S_ASTOP;
              end
              RID_HMADR: q.hmadr <= cpu_wdata;
              RID_CNTL: begin
                q.cntl <= cpu_wdata;
                if (cpu_wdata[0]) begin
                  q.sts[0] <= 1'b0;
                  if (cpu_wdata[1]) st <= busy ? S_RSTOP : S_RSTART;
                end
              end
              RID_MODE:   q.mode   <= cpu_wdata & MODE_WM;
              RID_STS:    q.sts    <= q.sts & ~(cpu_wdata & STS_W1C);
              RID_EXT:    q.ext    <= q.ext & ~(cpu_wdata & EXT_W1C);
              RID_LSADR:  q.lsadr  <= cpu_wdata;
              RID_HSADR:  q.hsadr  <= cpu_wdata;
              RID_CLKDIV: q.clkdiv <= cpu_wdata;
              RID_IMASK:  q.imask  <= cpu_wdata;
              RID_XFR:    q.xfr    <= cpu_wdata & XFR_WM;
              RID_XCTL: begin
                if (cpu_wdata[0]) q <= REGS_RST;
                else              q.xctl <= cpu_wdata;
              end
              RID_DIRC:   q.dirc <= cpu_wdata & DIRC_WM;
              RID_INTR:   q.intr <= cpu_wdata;
              default: ;
            endcase
          end else begin
            rdata_q <= rd_mux;
            if (id == RID_MDATA && q.sts[5]) st <= S_RECV;
          end
        end
        S_WSTART: if (res_valid) begin
          if (res_ack) begin
            busy     <= 1'b1;
            q.sts[0] <= 1'b1;
            q.sts[2] <= 1'b0;
            q.ext    <= '0;
            st       <= S_WSEND;
          end else begin
            q.sts[0] <= 1'b0;
            q.sts[2] <= 1'b1;
            q.ext[0] <= 1'b1;
            st       <= S_FIN;
          end
        end
        S_WSEND: if (res_valid) begin
          if (res_ack) st <= S_FIN;
          else begin
            q.sts[0] <= 1'b0;
            q.sts[2] <= 1'b1;
            q.ext[0] <= 1'b1;
            st       <= S_WSTOP;
          end
        end
        S_WSTOP, S_ASTOP: if (res_valid) begin
          busy <= 1'b0;
          st   <= S_FIN;
        end
        S_RSTOP: if (res_valid) begin
          busy <= 1'b0;
          st   <= S_RSTART;
        end
        S_RRESTOP: if (res_valid) begin
          busy <= 1'b0;
          st   <= S_RRESTART;
        end
        S_RSTART, S_RRESTART: if (res_valid) begin
          if (res_ack) begin
            busy     <= 1'b1;
            q.sts[5] <= 1'b1;
            q.sts[2] <= 1'b0;
            q.ext    <= '0;
          end else begin
            q.sts[0] <= 1'b0;
            q.sts[2] <= 1'b1;
            q.ext[0] <= 1'b1;
          end
          if (st == S_RRESTART) q.cntl[5:4] <= q.cntl[5:4] - 2'd1;
          st <= S_FIN;
        end
        S_RECV: if (res_valid) begin
          rdata_q <= res_ack ? res_data : IDLE_RD;
          if (q.cntl[5:4] == 2'd0) begin
            q.sts[5] <= 1'b0;
            st       <= S_FIN;
          end else begin
            st <= S_RRESTOP;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R13: completion is a single-cycle pulse
  a_r13_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R13: the access never completes with a command still at the engine
  a_r13_ready_after_done: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !cmd_valid);

  // R2: values seen right after reset release
  a_r2_reset_vals: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q.ext == 8'h8F && q.dirc == 8'h0F && q.sts == 8'h00));

  // R4: a status write never sets a bit
  a_r4_sts_w1c: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && cpu_sel && cpu_we && id == RID_STS)
      |=> ((q.sts & ~$past(q.sts)) == 8'h00));

  // R3: masked-out transfer-count bits stay clear
  a_r3_xfr_mask: assert property (@(posedge clk) disable iff (rst)
    (q.xfr & 8'h88) == 8'h00);

  // R6: every start carries the low address shifted right by one
  a_r6_start_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op_e == OP_START_WR || cmd_op_e == OP_START_RD))
      |-> (cmd_byte == {1'b0, q.lmadr[BYTE_W-1:1]}));

  // R11: a repeated read start decrements the pending count by one
  a_r11_count_dec: assert property (@(posedge clk) disable iff (rst)
    (st == S_RRESTART && res_valid) |=> (q.cntl[5:4] == $past(q.cntl[5:4]) - 2'd1));

endmodule

// File: tb/i2c_master_regif_tb_top.sv
module i2c_master_regif_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {offset, write value, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h02_A5_A5, 24'h05_3C_3C, 24'h07_FF_DF, 24'h0A_11_11,
    24'h0B_22_22, 24'h0C_55_55, 24'h0D_0F_0F, 24'h0E_FF_77,
    24'h10_FF_07, 24'h11_81_81, 24'h01_FF_00, 24'h03_FF_00,
    24'h12_FF_00, 24'h1F_FF_00
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_ready;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0] eng_rdata = '0;

  int checks = 0;
  int errors = 0;

  // engine model controls and command log
  logic [7:0] nak_addr = 8'hFF;
  logic       nak_send = 1'b0;
  logic       rx_fail  = 1'b0;
  logic [7:0] rx_next  = 8'h00;
  logic [2:0] log_op [64];
  logic [7:0] log_b  [64];
  int nlog = 0;
  int rp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_master_regif dut_i (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata)
  );

  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      else if (cmd_valid) begin
        if (wcnt == 1) begin
          wcnt = 0;
          case (cmd_op)
            3'd0, 3'd1: eng_ack = (cmd_byte != nak_addr);
            3'd2: eng_ack = !nak_send;
            3'd3: begin eng_ack = !rx_fail; eng_rdata = rx_next; rx_next = rx_next + 8'd1; end
            default: eng_ack = 1'b1;
          endcase
          if (nlog < 64) begin log_op[nlog] = cmd_op; log_b[nlog] = cmd_byte; end
          nlog++;
          eng_done = 1'b1;
        end else wcnt++;
      end
    end
  end

  task automatic cpu_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    do @(negedge clk); while (!cpu_ready);
    d = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    cpu_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pop_cmd(input string tag, input logic [2:0] op, input logic [7:0] b);
    checks++;
    if (rp >= nlog) begin
      errors++;
      $display("FAIL %s: got no command expected op %0d byte %02h", tag, op, b);
    end else if (log_op[rp] !== op || log_b[rp] !== b) begin
      errors++;
      $display("FAIL %s: got op %0d byte %02h expected op %0d byte %02h",
               tag, log_op[rp], log_b[rp], op, b);
    end
    rp++;
  endtask

  task automatic no_cmd(input string tag);
    checks++;
    if (rp != nlog) begin
      errors++;
      $display("FAIL %s: got %0d extra commands expected 0", tag, nlog - rp);
      rp = nlog;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R2 reset values
    chk_rd("R2 ext", 5'h09, 8'h8F);
    chk_rd("R2 dirc", 5'h10, 8'h0F);
    chk_rd("R2 cntl", 5'h06, 8'h00);
    chk_rd("R2 sts", 5'h08, 8'h00);
    // R1 idle data read
    chk_rd("R1 idle data", 5'h00, 8'hFF);
    no_cmd("R1 no command");

    // R3/R1 vector walk
    for (int i = 0; i < NVEC; i++) begin
      cpu_wr(VEC[i][23:16], VEC[i][15:8]);
      cpu_rd(VEC[i][23:16], d);
      if (VEC[i][23:16] == 5'h01 || VEC[i][23:16] == 5'h03 || VEC[i][23:16] >= 5'h12)
        chk("R1 unmapped", d, VEC[i][7:0]);
      else
        chk("R3 masked store", d, VEC[i][7:0]);
    end
    chk_rd("R1 neighbour kept", 5'h02, 8'hA5);
    chk_rd("R1 lmadr kept", 5'h04, 8'h00);

    // R5 soft reset
    cpu_wr(5'h0F, 8'h01);
    chk_rd("R5 clkdiv cleared", 5'h0C, 8'h00);
    chk_rd("R5 ext restored", 5'h09, 8'h8F);
    chk_rd("R5 not stored", 5'h0F, 8'h00);
    cpu_wr(5'h0F, 8'h02);
    chk_rd("R5 stored", 5'h0F, 8'h02);

    // R4 extended status write-one-to-clear
    cpu_wr(5'h09, 8'h05);
    chk_rd("R4 ext partial", 5'h09, 8'h8A);
    cpu_wr(5'h09, 8'hFF);
    chk_rd("R4 ext all", 5'h09, 8'h00);

    // R12 idle address write, R6 write start then send
    cpu_wr(5'h04, 8'hA0);
    no_cmd("R12 idle no stop");
    cpu_wr(5'h00, 8'h5A);
    pop_cmd("R6 R13 write start", 3'd0, 8'h50);
    pop_cmd("R6 R13 send", 3'd2, 8'h5A);
    no_cmd("R13 done by ready");
    chk_rd("R6 sts PT", 5'h08, 8'h01);
    cpu_wr(5'h00, 8'h33);
    pop_cmd("R6 send only", 3'd2, 8'h33);
    no_cmd("R6 no restart");

    // R9 PT without read
    cpu_wr(5'h06, 8'h01);
    no_cmd("R9 no command");
    chk_rd("R9 PT cleared", 5'h08, 8'h00);
    chk_rd("R9 cntl stored", 5'h06, 8'h01);

    // R12 address write while open
    cpu_wr(5'h04, 8'hA2);
    pop_cmd("R12 stop", 3'd4, 8'h00);
    cpu_wr(5'h04, 8'hA2);
    no_cmd("R12 idle again");

    // R7 refused write start
    nak_addr = 8'h51;
    cpu_wr(5'h00, 8'h77);
    pop_cmd("R7 start refused", 3'd0, 8'h51);
    no_cmd("R7 no send");
    chk_rd("R7 sts", 5'h08, 8'h04);
    chk_rd("R7 ext", 5'h09, 8'h01);
    cpu_wr(5'h08, 8'hFF);
    chk_rd("R4 sts mask", 5'h08, 8'h04);
    cpu_wr(5'h09, 8'hFF);

    // R7 refused send
    nak_addr = 8'hFF;
    nak_send = 1'b1;
    cpu_wr(5'h00, 8'h44);
    pop_cmd("R7 start", 3'd0, 8'h51);
    pop_cmd("R7 send", 3'd2, 8'h44);
    pop_cmd("R7 stop", 3'd4, 8'h00);
    chk_rd("R7 sts send", 5'h08, 8'h04);
    chk_rd("R7 ext send", 5'h09, 8'h01);
    nak_send = 1'b0;

    // R8 read start from idle
    cpu_wr(5'h06, 8'h03);
    pop_cmd("R8 read start", 3'd1, 8'h51);
    chk_rd("R8 sts MDBS", 5'h08, 8'h20);
    chk_rd("R8 ext zero", 5'h09, 8'h00);

    // R10 single receive
    rx_next = 8'hC0;
    chk_rd("R10 data", 5'h00, 8'hC0);
    pop_cmd("R10 recv", 3'd3, 8'h00);
    chk_rd("R10 MDBS clear", 5'h08, 8'h00);
    chk_rd("R10 idle data", 5'h00, 8'hFF);
    no_cmd("R10 no recv");

    // R8 with bus open, R11 pending count
    cpu_wr(5'h06, 8'h23);
    pop_cmd("R8 stop first", 3'd4, 8'h00);
    pop_cmd("R8 restart", 3'd1, 8'h51);
    chk_rd("R11 first byte", 5'h00, 8'hC1);
    pop_cmd("R11 recv1", 3'd3, 8'h00);
    pop_cmd("R11 stop1", 3'd4, 8'h00);
    pop_cmd("R11 start1", 3'd1, 8'h51);
    chk_rd("R11 count 1", 5'h06, 8'h13);
    chk_rd("R11 MDBS held", 5'h08, 8'h20);
    chk_rd("R11 second byte", 5'h00, 8'hC2);
    pop_cmd("R11 recv2", 3'd3, 8'h00);
    pop_cmd("R11 stop2", 3'd4, 8'h00);
    pop_cmd("R11 start2", 3'd1, 8'h51);
    chk_rd("R11 count 0", 5'h06, 8'h03);
    chk_rd("R11 last byte", 5'h00, 8'hC3);
    pop_cmd("R11 recv3", 3'd3, 8'h00);
    no_cmd("R11 no restart");
    chk_rd("R11 MDBS clear", 5'h08, 8'h00);

    // R10 failed receive
    cpu_wr(5'h06, 8'h03);
    pop_cmd("R10 stop", 3'd4, 8'h00);
    pop_cmd("R10 start", 3'd1, 8'h51);
    rx_fail = 1'b1;
    chk_rd("R10 fail data", 5'h00, 8'hFF);
    pop_cmd("R10 recv fail", 3'd3, 8'h00);
    rx_fail = 1'b0;

    // R8 refused read start
    nak_addr = 8'h51;
    cpu_wr(5'h06, 8'h03);
    pop_cmd("R8 stop", 3'd4, 8'h00);
    pop_cmd("R8 start refused", 3'd1, 8'h51);
    chk_rd("R8 sts refused", 5'h08, 8'h04);
    chk_rd("R8 ext refused", 5'h09, 8'h01);
    cpu_wr(5'h04, 8'hA2);
    no_cmd("R12 closed after refusal");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule